// File: doc/BRIEF.md
# Seconds Counter with Alarm Wake-up and Drift Trim

This block keeps wall-clock time as a plain count of seconds. It runs from a slow reference clock of nominally 32.768 kHz. A prescaler turns that clock into one tick per second, and each tick advances a seconds register. Software can load the seconds register and read it back through a small register port that has one write cycle per access and a combinational read. Because the block has no dependency on the rest of the chip, it keeps counting while the system sleeps.

A crystal that runs fast or slow is corrected by a signed trim value. In the last second of every trim period, that second is made longer or shorter by the trim number of reference cycles, so the average length of a second comes back to its nominal value. An alarm register is compared with the count on every tick. When the count steps onto the alarm value, a sticky flag is set. Software clears the flag by writing a one. The flag, gated by an enable bit, drives the wake-up request for the rest of the system.

Register map (3-bit address): 0 seconds count, 1 alarm value, 2 control (bit 0 = alarm enable), 3 trim (signed two's complement in the low TRIM_W bits, read back sign-extended), 4 status (bit 0 = alarm flag; writing 1 to bit 0 clears it). Addresses 5 to 7 read as zero and ignore writes.

Top module: `sec_rtc`

## Requirements
- R1: Synchronous reset clears the seconds count, alarm value, alarm enable, trim and alarm flag, and holds the prescaler at phase zero, so every readable register returns 0 and wake_req is low.
- R2: With zero trim, sec_count increases by exactly one every DIV_CYCLES clock cycles and changes in no other way except by a load.
- R3: In the last second of every TRIM_PERIOD-second period, the second lasts DIV_CYCLES plus the signed trim value in cycles. Every other second lasts DIV_CYCLES cycles. A trim of zero changes nothing.
- R4: A write to address 0 loads the seconds count on that clock edge and restarts both the prescaler and the trim period, so the next increment comes DIV_CYCLES cycles after the write edge. A tick that falls on the same edge is dropped.
- R5: When a tick moves the count onto the alarm value, the alarm flag (status bit 0) is set on that same edge.
- R6: Writing an alarm value equal to the current count, or loading the count with a value equal to the alarm value, does not set the flag.
- R7: The flag stays set until a write to address 4 with bit 0 high. A write there with bit 0 low has no effect. If a set and a clear fall on the same edge, the set wins.
- R8: wake_req is high exactly when the alarm flag and the alarm enable (address 2, bit 0) are both set.
- R9: Reads return the count at address 0, the alarm value at 1, the enable in bit 0 at 2, the sign-extended trim at 3, the flag in bit 0 at 4, and zero at any other address.
- R10: The count wraps from all ones to zero, and a wrap onto an alarm value of zero sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 32.768 kHz |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| wr_addr | input | 3 | Write register select |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | CNT_W | Combinational read data |
| sec_count | output | CNT_W | Current seconds count |
| wake_req | output | 1 | Alarm wake-up request |

## Verification
A wrong prescaler phase or trim-period position shows up as a seconds increment that arrives early or late. The per-cycle reference model catches that on the first cycle the count differs, which is at most one trimmed second after the fault. A wrong flag or enable state appears on wake_req and on the status read in the very next cycle. A mistaken match condition shows up on the tick edge where the count reaches, or passes, the alarm value. Interval measurements around loads and trim settings pin the length of each second in cycles, independently of the model.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_SECONDS = 3'd0,
        REG_ALARM   = 3'd1,
        REG_CTRL    = 3'd2,
        REG_TRIM    = 3'd3,
        REG_STATUS  = 3'd4
    } reg_sel_e;

    // Prescaler outputs for the current cycle
    typedef struct packed {
        logic tick;       // this edge ends a second
        logic trim_due;   // current second carries the trim adjustment
    } pace_t;

    // One-hot-ish decoded write strobes
    typedef struct packed {
        logic load_sec;
        logic load_alarm;
        logic load_ctrl;
        logic load_trim;
        logic clear_flag;
    } wr_dec_t;

    // Phase counter width large enough for the longest trimmed second
    function automatic int phase_bits(input int div_cycles, input int trim_w);
        return $clog2(div_cycles + (1 << (trim_w - 1)) + 1);
    endfunction

    function automatic wr_dec_t decode_write(input logic en,
                                             input logic [ADDR_W-1:0] addr,
                                             input logic bit0);
        wr_dec_t d;
        d.load_sec   = en && (addr == REG_SECONDS);
        d.load_alarm = en && (addr == REG_ALARM);
        d.load_ctrl  = en && (addr == REG_CTRL);
        d.load_trim  = en && (addr == REG_TRIM);
        d.clear_flag = en && (addr == REG_STATUS) && bit0;
        return d;
    endfunction

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler
    import sec_rtc_pkg::*;
#(
    parameter int DIV_CYCLES  = 32768,
    parameter int TRIM_PERIOD = 60,
    parameter int TRIM_W      = 8
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         restart,
    input  logic signed [TRIM_W-1:0]                     trim,
    output pace_t                                        pace,
    output logic [phase_bits(DIV_CYCLES, TRIM_W)-1:0]    phase
);

    localparam int PH_W  = phase_bits(DIV_CYCLES, TRIM_W);
    localparam int PER_W = (TRIM_PERIOD > 1) ? $clog2(TRIM_PERIOD) : 1;

    logic [PER_W-1:0] sec_in_period;
    int               len_now;

    always_comb begin
        pace.trim_due = (int'(sec_in_period) == TRIM_PERIOD - 1);
        len_now       = DIV_CYCLES + (pace.trim_due ? int'(trim) : 0);
        pace.tick     = !restart && (int'(phase) == len_now - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase         <= '0;
            sec_in_period <= '0;
        end else if (pace.tick) begin
            phase         <= '0;
            sec_in_period <= pace.trim_due ? '0 : sec_in_period + 1'b1;
        end else begin
            phase         <= phase + 1'b1;
        end
    end

    // PH_W sized port relies on the package function
    initial begin
        if (PH_W < 1) $display("prescaler phase width is zero");
    end

endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_inc
);

    assign count_inc = count + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count_inc;
    end

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_alarm,
    input  logic [CNT_W-1:0] alarm_in,
    input  logic             load_ctrl,
    input  logic             enable_in,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] count_inc,
    output logic [CNT_W-1:0] alarm_val,
    output logic             alarm_en,
    output logic             flag,
    output logic             wake
);

    logic match;

    // Only a tick can produce a match: loads and alarm writes never fire
    assign match = tick && (count_inc == alarm_val);
    assign wake  = flag && alarm_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_val <= '0;
            alarm_en  <= 1'b0;
            flag      <= 1'b0;
        end else begin
            if (load_alarm) alarm_val <= alarm_in;
            if (load_ctrl)  alarm_en  <= enable_in;
            flag <= match || (flag && !clear);
        end
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DIV_CYCLES  = 32768,
    parameter int TRIM_PERIOD = 60,
    parameter int TRIM_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  sec_count,
    output logic              wake_req
);

    localparam int PH_W = phase_bits(DIV_CYCLES, TRIM_W);

    wr_dec_t                   dec;
    pace_t                     pace;
    logic [PH_W-1:0]           phase;
    logic signed [TRIM_W-1:0]  trim_q;
    logic [CNT_W-1:0]          count_inc;
    logic [CNT_W-1:0]          alarm_val;
    logic                      alarm_en;
    logic                      alarm_flag;
    logic                      tick;

    assign dec  = decode_write(wr_en, wr_addr, wr_data[0]);
    assign tick = pace.tick;

    always_ff @(posedge clk) begin
        if (rst)                trim_q <= '0;
        else if (dec.load_trim) trim_q <= wr_data[TRIM_W-1:0];
    end

    sec_rtc_prescaler #(
        .DIV_CYCLES (DIV_CYCLES),
        .TRIM_PERIOD(TRIM_PERIOD),
        .TRIM_W     (TRIM_W)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .restart(dec.load_sec),
        .trim   (trim_q),
        .pace   (pace),
        .phase  (phase)
    );

    sec_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (dec.load_sec),
        .load_val (wr_data),
        .tick     (tick),
        .count    (sec_count),
        .count_inc(count_inc)
    );

    sec_rtc_alarm #(.CNT_W(CNT_W)) u_alm (
        .clk       (clk),
        .rst       (rst),
        .load_alarm(dec.load_alarm),
        .alarm_in  (wr_data),
        .load_ctrl (dec.load_ctrl),
        .enable_in (wr_data[0]),
        .clear     (dec.clear_flag),
        .tick      (tick),
        .count_inc (count_inc),
        .alarm_val (alarm_val),
        .alarm_en  (alarm_en),
        .flag      (alarm_flag),
        .wake      (wake_req)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_SECONDS: rd_data = sec_count;
            REG_ALARM:   rd_data = alarm_val;
            REG_CTRL:    rd_data[0] = alarm_en;
            REG_TRIM:    rd_data = {{(CNT_W-TRIM_W){trim_q[TRIM_W-1]}}, trim_q};
            REG_STATUS:  rd_data[0] = alarm_flag;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
    import sec_rtc_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int DIV_CYCLES = 32768,
    parameter int TRIM_W     = 8
) (
    input logic                                      clk,
    input logic                                      rst,
    input logic                                      wr_en,
    input logic [ADDR_W-1:0]                         wr_addr,
    input logic [CNT_W-1:0]                          wr_data,
    input logic [CNT_W-1:0]                          sec_count,
    input logic                                      wake_req,
    input logic                                      tick,
    input logic [phase_bits(DIV_CYCLES, TRIM_W)-1:0] phase,
    input logic [CNT_W-1:0]                          alarm_val,
    input logic                                      alarm_en,
    input logic                                      alarm_flag
);

    logic wr_sec, wr_alm, wr_clr;
    assign wr_sec = wr_en && (wr_addr == REG_SECONDS);
    assign wr_alm = wr_en && (wr_addr == REG_ALARM);
    assign wr_clr = wr_en && (wr_addr == REG_STATUS) && wr_data[0];

    // R2: without a load the count only ever steps by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_sec) && (sec_count != $past(sec_count)))
            |-> (sec_count == $past(sec_count) + 1'b1));

    // R3: the phase never reaches the longest possible trimmed second
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(phase) < DIV_CYCLES + (1 << (TRIM_W - 1)));

    // R3: a tick returns the prescaler to phase zero
    p_tick_restart_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (phase == '0));

    // R4: a seconds write takes the data and restarts the prescaler
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_sec))
            |-> ((sec_count == $past(wr_data)) && (phase == '0)));

    // R5: the flag only rises on a tick onto the alarm value
    p_flag_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(alarm_flag) && !$past(wr_alm))
            |-> ($past(tick) && (sec_count == alarm_val)));

    // R7: a set flag holds unless cleared
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(alarm_flag) && !$past(rst) && !$past(wr_clr)) |-> alarm_flag);

    // R8: wake needs both flag and enable
    p_wake_gate_r8: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (alarm_flag && alarm_en));

endmodule

bind sec_rtc sec_rtc_chk #(
    .CNT_W     (CNT_W),
    .DIV_CYCLES(DIV_CYCLES),
    .TRIM_W    (TRIM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sec_count (sec_count),
    .wake_req  (wake_req),
    .tick      (tick),
    .phase     (phase),
    .alarm_val (alarm_val),
    .alarm_en  (alarm_en),
    .alarm_flag(alarm_flag)
);

// File: tb/sec_rtc_test.sv
module sec_rtc_test;

    localparam int CLK_PER = 20;
    localparam int CW      = 32;
    localparam int DIV     = 40;
    localparam int PER     = 3;
    localparam int TW      = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic [CW-1:0] sec_count;
    logic          wake_req;

    int checks = 0;
    int fails  = 0;

    sec_rtc #(.CNT_W(CW), .DIV_CYCLES(DIV), .TRIM_PERIOD(PER), .TRIM_W(TW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sec_count(sec_count), .wake_req(wake_req)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Behavioural reference: time elapsed inside the current second
    logic [CW-1:0] m_sec, m_alarm;
    int            m_phase, m_persec, m_trim, m_len;
    bit            m_en, m_flag, m_tick;

    function automatic int sec_len();
        return DIV + ((m_persec == PER - 1) ? m_trim : 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sec = '0; m_alarm = '0; m_phase = 0; m_persec = 0;
            m_trim = 0; m_en = 0; m_flag = 0;
        end else begin
            m_len  = sec_len();
            m_tick = 0;
            if (wr_en && wr_addr == 3'd0) begin
                m_sec = wr_data; m_phase = 0; m_persec = 0;
            end else if (m_phase + 1 == m_len) begin
                m_tick = 1; m_phase = 0; m_sec = m_sec + 1;
                m_persec = (m_persec == PER - 1) ? 0 : m_persec + 1;
            end else begin
                m_phase = m_phase + 1;
            end
            if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_flag = 0;
            if (m_tick && m_sec == m_alarm) m_flag = 1;
            if (wr_en && wr_addr == 3'd1) m_alarm = wr_data;
            if (wr_en && wr_addr == 3'd2) m_en = wr_data[0];
            if (wr_en && wr_addr == 3'd3) m_trim = $signed(wr_data[TW-1:0]);
        end
    end

    function automatic logic [CW-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_sec;
            3'd1:    return m_alarm;
            3'd2:    return {{(CW-1){1'b0}}, m_en};
            3'd3:    return CW'(m_trim);
            3'd4:    return {{(CW-1){1'b0}}, m_flag};
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison a quarter period after each edge
    always @(posedge clk) begin
        #(CLK_PER/4);
        if (!rst) begin
            check("R2 count vs model", sec_count, m_sec);
            check("R8 wake vs model", {31'b0, wake_req}, {31'b0, m_flag && m_en});
            check("R9 read vs model", rd_data, model_read(rd_addr));
        end
    end

    task automatic wr_now(input logic [2:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Negedges until sec_count changes
    task automatic wait_change(output int n);
        logic [CW-1:0] prev;
        prev = sec_count;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sec_count == prev && n < 1000);
    endtask

    task automatic read_chk(input string tag, input logic [2:0] a, input logic [CW-1:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        #(CLK_PER * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, a, b, c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 8; i++) read_chk("R1 reset read", 3'(i), '0);
        check("R1 wake low", {31'b0, wake_req}, '0);

        // R2 untrimmed second length
        wait_change(n);
        wait_change(n); check("R2 interval", n, DIV);
        wait_change(n); check("R2 interval", n, DIV);

        // R9 unused address ignores writes
        wr(3'd6, 32'hDEAD_BEEF);
        read_chk("R9 unused reads zero", 3'd6, '0);

        // R3 positive trim, R4 load alignment
        wr(3'd3, 32'd5);
        read_chk("R9 trim readback", 3'd3, 32'd5);
        wr(3'd0, 32'd1000);
        read_chk("R4 load value", 3'd0, 32'd1000);
        wait_change(n); check("R4 first second after load", n, DIV);
        wait_change(a); wait_change(b); wait_change(c);
        check("R3 plain second", a, DIV);
        check("R3 lengthened second", b, DIV + 5);
        check("R3 plain second after trim", c, DIV);

        // R3 negative trim
        wr(3'd3, 32'hFFFF_FFF9);
        read_chk("R9 trim sign extension", 3'd3, 32'hFFFF_FFF9);
        wr(3'd0, 32'd2000);
        wait_change(n);
        wait_change(a); wait_change(b); wait_change(c);
        check("R3 plain second", a, DIV);
        check("R3 shortened second", b, DIV - 7);
        check("R3 plain second after trim", c, DIV);
        wr(3'd3, 32'd0);

        // R5 alarm match and R8 wake
        wr(3'd0, 32'd100);
        wr(3'd1, 32'd102);
        wr(3'd2, 32'd1);
        read_chk("R9 ctrl readback", 3'd2, 32'd1);
        wait_change(n);
        read_chk("R5 no flag before match", 3'd4, 32'd0);
        wait_change(n);
        read_chk("R5 flag at match", 3'd4, 32'd1);
        check("R8 wake when enabled", {31'b0, wake_req}, 32'd1);

        // R7 sticky flag, write of zero ignored
        wait_change(n);
        read_chk("R7 flag sticky", 3'd4, 32'd1);
        wr(3'd4, 32'd0);
        read_chk("R7 zero write ignored", 3'd4, 32'd1);
        wr(3'd2, 32'd0);
        check("R8 wake gated off", {31'b0, wake_req}, '0);
        wr(3'd4, 32'd1);
        read_chk("R7 flag cleared", 3'd4, 32'd0);

        // R6 alarm written equal to current count
        wait_change(n);
        wr(3'd1, sec_count);
        idle(DIV - 5);
        read_chk("R6 alarm equal to count", 3'd4, 32'd0);

        // R6 count loaded equal to alarm
        wr(3'd1, 32'd500);
        wr(3'd0, 32'd500);
        idle(DIV - 5);
        read_chk("R6 load equal to alarm", 3'd4, 32'd0);

        // R7 set wins over a simultaneous clear
        wr(3'd2, 32'd1);
        wait_change(n);
        wr(3'd1, sec_count + 1);
        while (m_phase + 1 != sec_len()) @(negedge clk);
        wr_now(3'd4, 32'd1);
        read_chk("R7 set beats clear", 3'd4, 32'd1);
        check("R8 wake after set", {31'b0, wake_req}, 32'd1);
        wr(3'd4, 32'd1);

        // R10 wrap onto alarm zero
        wr(3'd1, 32'd0);
        wr(3'd0, 32'hFFFF_FFFF);
        wait_change(n);
        read_chk("R10 wrap to zero", 3'd0, 32'd0);
        read_chk("R10 wrap sets flag", 3'd4, 32'd1);
        check("R10 wake on wrap", {31'b0, wake_req}, 32'd1);

        idle(5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule